// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Winner-Take-All Neuron Layer

This block is a layer of digital spiking output neurons. Every clock cycle each neuron receives one unsigned input current, already summed over its synapses. Each neuron keeps a membrane accumulator that loses a fixed fraction of its value per cycle and adds the incoming current. When the accumulator reaches the neuron's threshold, the neuron emits a spike. The accumulator then clears and holds at zero for a programmable refractory time. The spike also silences every other neuron for a programmable inhibition time.

Each spike raises a learning request that carries the index of the neuron that fired. The request stays asserted until the synapse updater acknowledges it, and the whole layer is frozen while it waits. An optional homeostasis unit counts spikes per neuron over a programmable epoch. At the end of each epoch it moves each neuron's threshold one step toward an even firing rate.

Top module: `lif_wta_layer`

## Requirements
- R1: While reset is asserted and right after it, `spike_valid_o` and `learn_req_o` are low, `spike_vec_o` is zero, and every threshold on `thr_o` equals `cfg_thr_i` (all homeostatic offsets are zero).
- R2: A neuron that is free to integrate in a cycle computes V' = V + I - (V >> k), where k is `cfg_leak_i`. It fires when V' is greater than or equal to its threshold. The spike appears on the outputs in the following cycle.
- R3: V' saturates at the largest accumulator value (all ones) instead of wrapping. A threshold equal to that maximum can therefore still be reached.
- R4: A spike is a one-cycle pulse on `spike_valid_o`. `spike_vec_o` then has exactly the bit of the firing neuron set, and it is zero in every other cycle.
- R5: When several neurons reach threshold in the same cycle, only the one with the lowest index fires and is reported on `spike_idx_o`. The others keep their newly integrated value.
- R6: The firing neuron's accumulator becomes zero and stays zero for `cfg_refr_i` cycles, during which it neither integrates nor fires.
- R7: After a spike, every other neuron holds its accumulator, without integrating or firing, for `cfg_inhib_i` cycles.
- R8: A spike sets `learn_req_o` and loads `learn_idx_o` with the winner's index. Both hold until a cycle with `learn_ack_i` high. While the request is high, no neuron integrates or fires.
- R9: With `cfg_homeo_en_i` high, an epoch lasts `cfg_epoch_i`+1 cycles. At its end, a neuron whose spike count is above `cfg_target_i` gets its offset raised by one, and one below the target gets it lowered by one. The effective threshold is `cfg_thr_i` + offset × THR_STEP, and the counts restart from zero.
- R10: Offsets are clamped to ±OFF_LIM. The effective threshold is clamped to the range from 1 to the accumulator maximum.
- R11: With `cfg_homeo_en_i` low, offsets do not change, so thresholds follow only `cfg_thr_i`. Spike counts and the epoch counter are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_i | input | N_NEURONS*CUR_W | Input current per neuron, neuron 0 in the low bits |
| cfg_thr_i | input | ACC_W | Base firing threshold |
| cfg_leak_i | input | SH_W | Leak shift k |
| cfg_refr_i | input | TMR_W | Refractory length in cycles |
| cfg_inhib_i | input | TMR_W | Inhibition length in cycles |
| cfg_homeo_en_i | input | 1 | Homeostasis enable |
| cfg_epoch_i | input | EP_W | Epoch length minus one |
| cfg_target_i | input | CNT_W | Target spike count per epoch |
| learn_ack_i | input | 1 | Learning step done |
| spike_valid_o | output | 1 | Spike pulse |
| spike_vec_o | output | N_NEURONS | One-hot firing neuron |
| spike_idx_o | output | IDX_W | Index of firing neuron |
| learn_req_o | output | 1 | Learning request, held until acknowledged |
| learn_idx_o | output | IDX_W | Neuron whose synapses are to be updated |
| thr_o | output | N_NEURONS*ACC_W | Effective threshold per neuron |

## Verification
On every cycle, the assertions check the output protocol: the spike vector is one-hot only during a spike, and the reported index matches the set bit. They also check that each spike raises the learning request with the same index, and that the request and its index hold until acknowledged with no spike while they wait. Thresholds are checked to stay nonzero, and to stay fixed while homeostasis is off. The numerical behaviour cannot be shown by the assertions alone and relies on the bench's scenarios, compared against its own cycle model: the leak arithmetic, saturation at the maximum, the lowest-index tie rule, refractory and inhibition lengths, and the per-epoch threshold steps and their clamps.

// File: rtl/lif_pkg.sv
package lif_pkg;
  typedef enum logic [1:0] {
    HD_KEEP = 2'd0,
    HD_UP   = 2'd1,
    HD_DOWN = 2'd2
  } homeo_dir_e;
endpackage

// File: rtl/lif_neuron.sv
module lif_neuron #(
  parameter int ACC_W = 12,
  parameter int CUR_W = 8,
  parameter int SH_W  = 3,
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CUR_W-1:0] cur_i,
  input  logic [ACC_W-1:0] thr_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [TMR_W-1:0] refr_len_i,
  input  logic             gate_i,
  input  logic             win_i,
  output logic             cross_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc_q, acc_d, sum_sat;
  logic [TMR_W-1:0] refr_q, refr_d;
  logic [ACC_W:0]   sum_w;
  logic             integ;

  always_comb begin
    integ   = gate_i && (refr_q == '0);
    sum_w   = {1'b0, acc_q - (acc_q >> shift_i)} + {{(ACC_W+1-CUR_W){1'b0}}, cur_i};
    sum_sat = sum_w[ACC_W] ? ACC_MAX : sum_w[ACC_W-1:0];
    cross_o = integ && (sum_sat >= thr_i);
  end

  always_comb begin
    acc_d  = acc_q;
    refr_d = refr_q;
    if (refr_q != '0) begin
      acc_d  = '0;
      refr_d = refr_q - 1'b1;
    end else if (win_i) begin
      acc_d  = '0;
      refr_d = refr_len_i;
    end else if (integ) begin
      acc_d  = sum_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      refr_q <= '0;
    end else begin
      acc_q  <= acc_d;
      refr_q <= refr_d;
    end
  end
endmodule

// File: rtl/lif_arbiter.sv
module lif_arbiter #(
  parameter int N_NEURONS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [N_NEURONS-1:0] req_i,
  output logic                 any_o,
  output logic [N_NEURONS-1:0] onehot_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_NEURONS - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o    = |req_i;
    onehot_o = any_o ? (N_NEURONS'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/lif_homeostasis.sv
module lif_homeostasis
  import lif_pkg::*;
#(
  parameter int N_NEURONS = 4,
  parameter int ACC_W     = 12,
  parameter int CNT_W     = 6,
  parameter int EP_W      = 10,
  parameter int OFF_LIM   = 4,
  parameter int THR_STEP  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_i,
  input  logic [EP_W-1:0]            epoch_i,
  input  logic [CNT_W-1:0]           target_i,
  input  logic [ACC_W-1:0]           thr_base_i,
  input  logic [N_NEURONS-1:0]       fire_i,
  output logic [N_NEURONS*ACC_W-1:0] thr_o
);
  localparam int OFF_W = $clog2(OFF_LIM + 1) + 1;
  localparam int RAW_W = ACC_W + 2;
  localparam logic signed [OFF_W-1:0] OFF_HI = OFF_W'(OFF_LIM);
  localparam logic signed [OFF_W-1:0] OFF_LO = -OFF_W'(OFF_LIM);
  localparam logic signed [RAW_W-1:0] STEP_S = RAW_W'(THR_STEP);
  localparam logic signed [RAW_W-1:0] RAW_MAX = RAW_W'({ACC_W{1'b1}});
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [EP_W-1:0] ep_q, ep_d;
  logic            ep_end;

  always_comb begin
    ep_end = en_i && (ep_q >= epoch_i);
    if (!en_i || ep_end) ep_d = '0;
    else                 ep_d = ep_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ep_q <= '0;
    else        ep_q <= ep_d;
  end

  for (genvar g = 0; g < N_NEURONS; g++) begin : g_unit
    logic [CNT_W-1:0]        cnt_q, cnt_d, tot;
    logic signed [OFF_W-1:0] off_q, off_d;
    logic signed [RAW_W-1:0] raw;
    homeo_dir_e              dir;

    always_comb begin
      tot = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(fire_i[g]);
      if (tot > target_i)      dir = HD_UP;
      else if (tot < target_i) dir = HD_DOWN;
      else                     dir = HD_KEEP;
      cnt_d = tot;
      off_d = off_q;
      if (!en_i) begin
        cnt_d = '0;
      end else if (ep_end) begin
        cnt_d = '0;
        if (dir == HD_UP && off_q != OFF_HI)   off_d = off_q + 1'b1;
        if (dir == HD_DOWN && off_q != OFF_LO) off_d = off_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        off_q <= '0;
      end else begin
        cnt_q <= cnt_d;
        off_q <= off_d;
      end
    end

    always_comb begin
      raw = $signed({2'b00, thr_base_i}) + RAW_W'(off_q) * STEP_S;
      if (raw < RAW_W'(1))     thr_o[g*ACC_W +: ACC_W] = ACC_W'(1);
      else if (raw > RAW_MAX)  thr_o[g*ACC_W +: ACC_W] = '1;
      else                     thr_o[g*ACC_W +: ACC_W] = raw[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/lif_wta_layer.sv
module lif_wta_layer #(
  parameter int N_NEURONS = 4,
  parameter int ACC_W     = 12,
  parameter int CUR_W     = 8,
  parameter int SH_W      = 3,
  parameter int TMR_W     = 6,
  parameter int EP_W      = 10,
  parameter int CNT_W     = 6,
  parameter int OFF_LIM   = 4,
  parameter int THR_STEP  = 8,
  localparam int IDX_W    = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_NEURONS*CUR_W-1:0] cur_i,
  input  logic [ACC_W-1:0]           cfg_thr_i,
  input  logic [SH_W-1:0]            cfg_leak_i,
  input  logic [TMR_W-1:0]           cfg_refr_i,
  input  logic [TMR_W-1:0]           cfg_inhib_i,
  input  logic                       cfg_homeo_en_i,
  input  logic [EP_W-1:0]            cfg_epoch_i,
  input  logic [CNT_W-1:0]           cfg_target_i,
  input  logic                       learn_ack_i,
  output logic                       spike_valid_o,
  output logic [N_NEURONS-1:0]       spike_vec_o,
  output logic [IDX_W-1:0]           spike_idx_o,
  output logic                       learn_req_o,
  output logic [IDX_W-1:0]           learn_idx_o,
  output logic [N_NEURONS*ACC_W-1:0] thr_o
);
  logic [N_NEURONS-1:0]       cross_vec, win_vec, gate_vec;
  logic [IDX_W-1:0]           win_idx;
  logic                       any_win;
  logic [N_NEURONS*ACC_W-1:0] thr_w;

  logic [TMR_W-1:0]     inh_q, inh_d;
  logic [IDX_W-1:0]     src_q, src_d, sidx_q, sidx_d, lidx_q, lidx_d;
  logic                 req_q, req_d, sv_q, sv_d;
  logic [N_NEURONS-1:0] vec_q, vec_d;

  for (genvar g = 0; g < N_NEURONS; g++) begin : g_nrn
    assign gate_vec[g] = !req_q && ((inh_q == '0) || (src_q == IDX_W'(g)));

    lif_neuron #(
      .ACC_W(ACC_W), .CUR_W(CUR_W), .SH_W(SH_W), .TMR_W(TMR_W)
    ) u_nrn (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur_i      (cur_i[g*CUR_W +: CUR_W]),
      .thr_i      (thr_w[g*ACC_W +: ACC_W]),
      .shift_i    (cfg_leak_i),
      .refr_len_i (cfg_refr_i),
      .gate_i     (gate_vec[g]),
      .win_i      (win_vec[g]),
      .cross_o    (cross_vec[g])
    );
  end

  lif_arbiter #(.N_NEURONS(N_NEURONS), .IDX_W(IDX_W)) u_arb (
    .req_i    (cross_vec),
    .any_o    (any_win),
    .onehot_o (win_vec),
    .idx_o    (win_idx)
  );

  lif_homeostasis #(
    .N_NEURONS(N_NEURONS), .ACC_W(ACC_W), .CNT_W(CNT_W), .EP_W(EP_W),
    .OFF_LIM(OFF_LIM), .THR_STEP(THR_STEP)
  ) u_homeo (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (cfg_homeo_en_i),
    .epoch_i    (cfg_epoch_i),
    .target_i   (cfg_target_i),
    .thr_base_i (cfg_thr_i),
    .fire_i     (win_vec),
    .thr_o      (thr_w)
  );

  always_comb begin
    inh_d  = (inh_q != '0) ? inh_q - 1'b1 : inh_q;
    src_d  = src_q;
    sidx_d = sidx_q;
    lidx_d = lidx_q;
    req_d  = (req_q && learn_ack_i) ? 1'b0 : req_q;
    sv_d   = any_win;
    vec_d  = win_vec;
    if (any_win) begin
      inh_d  = cfg_inhib_i;
      src_d  = win_idx;
      sidx_d = win_idx;
      lidx_d = win_idx;
      req_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q  <= '0;
      src_q  <= '0;
      sidx_q <= '0;
      lidx_q <= '0;
      req_q  <= 1'b0;
      sv_q   <= 1'b0;
      vec_q  <= '0;
    end else begin
      inh_q  <= inh_d;
      src_q  <= src_d;
      sidx_q <= sidx_d;
      lidx_q <= lidx_d;
      req_q  <= req_d;
      sv_q   <= sv_d;
      vec_q  <= vec_d;
    end
  end

  assign spike_valid_o = sv_q;
  assign spike_vec_o   = vec_q;
  assign spike_idx_o   = sidx_q;
  assign learn_req_o   = req_q;
  assign learn_idx_o   = lidx_q;
  assign thr_o         = thr_w;
endmodule

// File: rtl/lif_wta_layer_chk.sv
module lif_wta_layer_chk #(
  parameter int N_NEURONS = 4,
  parameter int ACC_W     = 12,
  parameter int CUR_W     = 8,
  parameter int SH_W      = 3,
  parameter int TMR_W     = 6,
  parameter int EP_W      = 10,
  parameter int CNT_W     = 6,
  parameter int IDX_W     = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_NEURONS*CUR_W-1:0] cur_i,
  input logic [ACC_W-1:0]           cfg_thr_i,
  input logic [SH_W-1:0]            cfg_leak_i,
  input logic [TMR_W-1:0]           cfg_refr_i,
  input logic [TMR_W-1:0]           cfg_inhib_i,
  input logic                       cfg_homeo_en_i,
  input logic [EP_W-1:0]            cfg_epoch_i,
  input logic [CNT_W-1:0]           cfg_target_i,
  input logic                       learn_ack_i,
  input logic                       spike_valid_o,
  input logic [N_NEURONS-1:0]       spike_vec_o,
  input logic [IDX_W-1:0]           spike_idx_o,
  input logic                       learn_req_o,
  input logic [IDX_W-1:0]           learn_idx_o,
  input logic [N_NEURONS*ACC_W-1:0] thr_o
);
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    spike_valid_o |-> $countones(spike_vec_o) == 1);

  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !spike_valid_o |-> spike_vec_o == '0);

  a_r5_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
    spike_valid_o |-> spike_vec_o[spike_idx_o]);

  a_r8_req_on_spike: assert property (@(posedge clk) disable iff (!rst_n)
    spike_valid_o |-> learn_req_o && learn_idx_o == spike_idx_o);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    learn_req_o && !learn_ack_i |=> learn_req_o && $stable(learn_idx_o));

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    learn_req_o |=> !spike_valid_o);

  a_r11_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_homeo_en_i ##1 $stable(cfg_thr_i) |-> $stable(thr_o));

  for (genvar g = 0; g < N_NEURONS; g++) begin : g_thr
    a_r10_thr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      thr_o[g*ACC_W +: ACC_W] != '0);
  end
endmodule

bind lif_wta_layer lif_wta_layer_chk #(
  .N_NEURONS(N_NEURONS), .ACC_W(ACC_W), .CUR_W(CUR_W), .SH_W(SH_W),
  .TMR_W(TMR_W), .EP_W(EP_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/lif_wta_layer_bench.sv
module lif_wta_layer_bench;
  localparam int N = 4, ACC_W = 12, CUR_W = 8, SH_W = 3, TMR_W = 6;
  localparam int EP_W = 10, CNT_W = 6, OFF_LIM = 4, STEP = 8, IDX_W = 2;
  localparam int ACC_MAX = (1 << ACC_W) - 1;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [N*CUR_W-1:0] cur_i;
  logic [ACC_W-1:0] cfg_thr_i;
  logic [SH_W-1:0] cfg_leak_i;
  logic [TMR_W-1:0] cfg_refr_i, cfg_inhib_i;
  logic cfg_homeo_en_i;
  logic [EP_W-1:0] cfg_epoch_i;
  logic [CNT_W-1:0] cfg_target_i;
  logic learn_ack_i;
  logic spike_valid_o, learn_req_o;
  logic [N-1:0] spike_vec_o;
  logic [IDX_W-1:0] spike_idx_o, learn_idx_o;
  logic [N*ACC_W-1:0] thr_o;

  always #10 clk = ~clk;

  lif_wta_layer u_lif_wta_layer (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_acc[N], m_refr[N], m_cnt[N], m_off[N];
  int m_inh, m_src, m_ep, m_idx, m_lidx;
  bit m_req, m_sv;
  int mode, ack_mode, hot;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int thr_of(int i);
    int v = int'(cfg_thr_i) + m_off[i] * STEP;
    if (v < 1) v = 1;
    if (v > ACC_MAX) v = ACC_MAX;
    return v;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_acc[i] = 0; m_refr[i] = 0; m_cnt[i] = 0; m_off[i] = 0;
    end
    m_inh = 0; m_src = 0; m_ep = 0; m_idx = 0; m_lidx = 0;
    m_req = 0; m_sv = 0;
  endfunction

  function automatic int gen_cur(int i);
    case (mode)
      1: return 60;
      2: return 255;
      3: return (i == hot) ? 40 : 0;
      default: return int'($urandom % 64);
    endcase
  endfunction

  function automatic void model_step(int c[N], bit ack);
    int win = -1;
    int nsum[N];
    bit integ[N];
    bit ep_end;
    for (int i = 0; i < N; i++) begin
      bit gate = !m_req && (m_inh == 0 || m_src == i);
      integ[i] = gate && m_refr[i] == 0;
      nsum[i] = m_acc[i] + c[i] - (m_acc[i] >> cfg_leak_i);
      if (nsum[i] > ACC_MAX) nsum[i] = ACC_MAX;
      if (win < 0 && integ[i] && nsum[i] >= thr_of(i)) win = i;
    end
    ep_end = cfg_homeo_en_i && m_ep >= int'(cfg_epoch_i);
    for (int i = 0; i < N; i++) begin
      int tot = m_cnt[i] + ((win == i) ? 1 : 0);
      if (tot > CNT_MAX) tot = CNT_MAX;
      if (!cfg_homeo_en_i) m_cnt[i] = 0;
      else if (ep_end) begin
        if (tot > int'(cfg_target_i) && m_off[i] < OFF_LIM) m_off[i]++;
        if (tot < int'(cfg_target_i) && m_off[i] > -OFF_LIM) m_off[i]--;
        m_cnt[i] = 0;
      end else m_cnt[i] = tot;
      if (m_refr[i] != 0) begin m_acc[i] = 0; m_refr[i]--; end
      else if (win == i) begin m_acc[i] = 0; m_refr[i] = int'(cfg_refr_i); end
      else if (integ[i]) m_acc[i] = nsum[i];
    end
    m_ep = (!cfg_homeo_en_i || ep_end) ? 0 : m_ep + 1;
    if (m_req && ack) m_req = 0;
    if (m_inh > 0) m_inh--;
    m_sv = (win >= 0);
    if (win >= 0) begin
      m_inh = int'(cfg_inhib_i); m_src = win; m_idx = win; m_lidx = win; m_req = 1;
    end
  endfunction

  task automatic step(string tag);
    int c[N];
    bit ack;
    for (int i = 0; i < N; i++) begin
      c[i] = gen_cur(i);
      cur_i[i*CUR_W +: CUR_W] = CUR_W'(c[i]);
    end
    case (ack_mode)
      1: ack = 1;
      2: ack = 0;
      default: ack = 1'($urandom % 2);
    endcase
    learn_ack_i = ack;
    model_step(c, ack);
    @(negedge clk);
    chk(tag, "spike_valid", int'(spike_valid_o), int'(m_sv));
    chk(tag, "spike_vec", int'(spike_vec_o), m_sv ? (1 << m_idx) : 0);
    if (m_sv) chk(tag, "spike_idx", int'(spike_idx_o), m_idx);
    chk(tag, "learn_req", int'(learn_req_o), int'(m_req));
    if (m_req) chk(tag, "learn_idx", int'(learn_idx_o), m_lidx);
    for (int i = 0; i < N; i++)
      chk(tag, "thr", int'(thr_o[i*ACC_W +: ACC_W]), thr_of(i));
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cur_i = '0; learn_ack_i = 0;
    cfg_thr_i = 12'd200; cfg_leak_i = 3'd3; cfg_refr_i = 6'd3; cfg_inhib_i = 6'd5;
    cfg_homeo_en_i = 0; cfg_epoch_i = 10'd50; cfg_target_i = 6'd2;
    mode = 0; ack_mode = 0; hot = 2;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "spike_valid", int'(spike_valid_o), 0);
    chk("R1", "learn_req", int'(learn_req_o), 0);
    chk("R1", "spike_vec", int'(spike_vec_o), 0);
    for (int i = 0; i < N; i++) chk("R1", "thr", int'(thr_o[i*ACC_W +: ACC_W]), 200);
    rst_n = 1;
    run(300, "R2");
    // R5: equal currents make every neuron cross together
    model_reset(); rst_n = 0; @(negedge clk); rst_n = 1;
    mode = 1; cfg_thr_i = 12'd100; ack_mode = 1; cfg_inhib_i = 6'd2; cfg_refr_i = 6'd1;
    run(60, "R5");
    // R3: saturating accumulator reaches the maximum threshold
    mode = 2; cfg_thr_i = 12'hFFF; cfg_leak_i = 3'd7;
    run(120, "R3");
    // R6: long refractory on a single driven neuron
    mode = 3; hot = 2; cfg_thr_i = 12'd150; cfg_leak_i = 3'd4; cfg_refr_i = 6'd20; cfg_inhib_i = 6'd0;
    run(150, "R6");
    // R7: long inhibition with random drive
    mode = 0; cfg_refr_i = 6'd0; cfg_inhib_i = 6'd30; cfg_thr_i = 12'd120;
    run(200, "R7");
    // R8: no acknowledge for a while, then acknowledge
    cfg_inhib_i = 6'd1; ack_mode = 2;
    run(60, "R8");
    ack_mode = 1;
    run(40, "R8");
    // R9: homeostasis toward a target count
    ack_mode = 0; cfg_homeo_en_i = 1; cfg_epoch_i = 10'd40; cfg_target_i = 6'd2;
    cfg_thr_i = 12'd150; cfg_inhib_i = 6'd3; cfg_refr_i = 6'd2;
    run(600, "R9");
    // R10: push offsets into both clamps
    cfg_target_i = 6'd0; cfg_epoch_i = 10'd20; cfg_thr_i = 12'd100;
    run(300, "R10");
    cfg_target_i = 6'd63; cfg_thr_i = 12'd10;
    run(300, "R10");
    // R11: homeostasis off, offsets frozen
    cfg_homeo_en_i = 0; cfg_thr_i = 12'd180;
    run(200, "R11");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule